// File: doc/BRIEF.md
# Local Periodic Countdown Timer

This block is a memory-mapped countdown timer with a programmable clock divider. A local vector-table entry turns each expiry into an interrupt request. Software reaches four registers over a simple register bus: the vector entry, the initial count, the live current count and the divide configuration. Writing a non-zero initial count loads the counter and starts it. The counter then steps down once per divided tick. When it reaches zero, the block raises a request that carries the programmed 8-bit vector, unless the entry is masked. In one-shot mode the counter then stops. In periodic mode it reloads on the following tick and runs again.

Requests leave on a valid/ready pair with the vector alongside. Once `irq_valid` is high, it stays high and `irq_vector` holds steady until a cycle in which `irq_ready` is also high; that cycle completes the transfer. While the consumer holds `irq_ready` low, one further expiry is kept as a single pending request with its own vector, and any expiry beyond that is lost. An expiry that occurs while the entry is masked is discarded outright and is never replayed when the mask is later cleared. Register reads are combinational. Register writes take effect at the clock edge on which `bus_we` is sampled high.

Top module: `lpt_timer`

## Requirements
- R1: After reset, offset 0x320 reads 0x00010000 (masked, one-shot, vector 0). Offsets 0x380, 0x390 and 0x3E0 read 0, and `irq_valid` is low.
- R2: Offsets are 0x320 for the vector entry, 0x380 for initial count, 0x390 for current count and 0x3E0 for divide configuration. In the vector entry, bits 7:0 hold the vector, bit 16 is the mask and bit 17 selects periodic mode. Divide configuration keeps only bits 3, 1 and 0. Every other bit, and every other address, reads as 0.
- R3: A non-zero write to initial count loads the current count at the write edge. The count then falls by one per tick. With divide code 1011b a tick occurs on every clock, so k cycles after the write it reads N-k.
- R4: In one-shot mode, the edge on which the count reaches zero raises exactly one request (N cycles after the write at divide-by-1). The count then stays at 0 and raises nothing further.
- R5: In periodic mode, the tick after zero reloads the initial count. Requests therefore repeat every N+1 ticks.
- R6: The divide code {bit3,bit1,bit0} sets the tick ratio: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1.
- R7: Writing 0 to initial count clears the count, stops the timer and raises no request.
- R8: An expiry while bit 16 is set is discarded. Clearing the mask afterwards raises nothing, and clearing it mid-count leaves the count undisturbed.
- R9: Current count is read-only, and writes to it have no effect.
- R10: While `irq_valid` is high and `irq_ready` is low, `irq_valid` stays high and `irq_vector` stays stable. The vector is the one programmed at the moment of expiry.
- R11: An expiry during an unaccepted request is held as one pending request, with the vector current at that expiry, and is delivered next. A further expiry while both are held is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vector | output | 8 | Vector of the request on offer |

## Verification
Each kind of wrong internal state shows up at the ports quickly. A wrong counter value appears on the very next read of offset 0x390, and it also moves the arrival cycle of the next request; the scoreboard compares that arrival to the exact cycle. A prescaler fault stretches or shrinks the spacing between periodic requests by whole multiples of the ratio within two periods. A fault in the mask or in the pending slot appears as an extra, missing or wrong-vector request at the next handshake after back-pressure is released.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  // register byte offsets (software visible)
  localparam logic [11:0] OFF_LVT  = 12'h320;
  localparam logic [11:0] OFF_INIT = 12'h380;
  localparam logic [11:0] OFF_CUR  = 12'h390;
  localparam logic [11:0] OFF_DIV  = 12'h3E0;
  // field positions inside the vector entry
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PER_BIT  = 17;
  // divide-configuration bit positions forming the 3-bit code
  localparam int DIV_HI_BIT  = 3;
  localparam int DIV_MID_BIT = 1;
  localparam int DIV_LO_BIT  = 0;
  localparam logic [2:0] DIV_CODE_ONE = 3'b111;
  // prescaler must reach ratio 128
  localparam int PRE_W = 7;

  // shift amount (log2 of ratio) for a divide code
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == DIV_CODE_ONE) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cur_count,
  output logic [VEC_W-1:0]  vec,
  output logic              mask,
  output logic              periodic,
  output logic [CNT_W-1:0]  init_count,
  output logic              init_wr,
  output logic [CNT_W-1:0]  init_wr_val,
  output logic [2:0]        div_code
);
  logic sel_lvt, sel_init, sel_cur, sel_div;

  assign sel_lvt  = (bus_addr == ADDR_W'(OFF_LVT));
  assign sel_init = (bus_addr == ADDR_W'(OFF_INIT));
  assign sel_cur  = (bus_addr == ADDR_W'(OFF_CUR));
  assign sel_div  = (bus_addr == ADDR_W'(OFF_DIV));

  assign init_wr     = bus_we && sel_init;
  assign init_wr_val = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec        <= '0;
      mask       <= 1'b1;
      periodic   <= 1'b0;
      init_count <= '0;
      div_code   <= 3'b000;
    end else if (bus_we) begin
      if (sel_lvt) begin
        vec      <= bus_wdata[VEC_W-1:0];
        mask     <= bus_wdata[LVT_MASK_BIT];
        periodic <= bus_wdata[LVT_PER_BIT];
      end
      if (sel_init) init_count <= bus_wdata[CNT_W-1:0];
      if (sel_div)
        div_code <= {bus_wdata[DIV_HI_BIT], bus_wdata[DIV_MID_BIT], bus_wdata[DIV_LO_BIT]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_lvt) begin
      bus_rdata[VEC_W-1:0]    = vec;
      bus_rdata[LVT_MASK_BIT] = mask;
      bus_rdata[LVT_PER_BIT]  = periodic;
    end else if (sel_init) begin
      bus_rdata[CNT_W-1:0] = init_count;
    end else if (sel_cur) begin
      bus_rdata[CNT_W-1:0] = cur_count;
    end else if (sel_div) begin
      bus_rdata[DIV_HI_BIT]  = div_code[2];
      bus_rdata[DIV_MID_BIT] = div_code[1];
      bus_rdata[DIV_LO_BIT]  = div_code[0];
    end
  end
endmodule

// File: rtl/lpt_prescale.sv
module lpt_prescale
  import lpt_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div_code,
  output logic       tick
);
  logic [W-1:0] pre_q;
  logic [W-1:0] lim;
  logic [2:0]   sh;

  assign sh   = div_shift(div_code);
  assign lim  = ~({W{1'b1}} << sh);
  assign tick = ((pre_q & lim) == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + W'(1);
  end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             init_wr,
  input  logic [CNT_W-1:0] init_wr_val,
  input  logic [CNT_W-1:0] init_count,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_count,
  output logic             expire
);
  logic running;
  logic at_one, at_zero;

  assign at_one  = (cur_count == CNT_W'(1));
  assign at_zero = (cur_count == '0);
  assign expire  = tick && running && at_one && !init_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_count <= '0;
      running   <= 1'b0;
    end else if (init_wr) begin
      cur_count <= init_wr_val;
      running   <= (init_wr_val != '0);
    end else if (tick && running) begin
      if (at_one) begin
        cur_count <= '0;
        if (!periodic) running <= 1'b0;
      end else if (at_zero) begin
        cur_count <= init_count;
      end else begin
        cur_count <= cur_count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lpt_irq_out.sv
module lpt_irq_out #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             mask,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             irq_ready,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic             pend_v;
  logic [VEC_W-1:0] pend_vec;
  logic             fire, hs;

  assign fire = expire && !mask;
  assign hs   = irq_valid && irq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      pend_v     <= 1'b0;
      pend_vec   <= '0;
    end else if (hs) begin
      if (pend_v) begin
        irq_vector <= pend_vec;
        pend_v     <= fire;
        if (fire) pend_vec <= vec_in;
      end else begin
        irq_valid <= fire;
        if (fire) irq_vector <= vec_in;
      end
    end else if (fire) begin
      if (!irq_valid) begin
        irq_valid  <= 1'b1;
        irq_vector <= vec_in;
      end else if (!pend_v) begin
        pend_v   <= 1'b1;
        pend_vec <= vec_in;
      end
    end
  end
endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0] tmr_vec;
  logic             tmr_mask, tmr_periodic;
  logic [CNT_W-1:0] init_count, init_wr_val, cur_count;
  logic             init_wr, tick, expire;
  logic [2:0]       div_code;

  lpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cur_count(cur_count),
    .vec(tmr_vec), .mask(tmr_mask), .periodic(tmr_periodic),
    .init_count(init_count), .init_wr(init_wr), .init_wr_val(init_wr_val),
    .div_code(div_code)
  );

  lpt_prescale #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .tick(tick)
  );

  lpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .init_wr(init_wr),
    .init_wr_val(init_wr_val), .init_count(init_count),
    .periodic(tmr_periodic), .cur_count(cur_count), .expire(expire)
  );

  lpt_irq_out #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mask(tmr_mask),
    .vec_in(tmr_vec), .irq_ready(irq_ready), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );
endmodule

// File: rtl/lpt_timer_chk.sv
module lpt_timer_chk
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [CNT_W-1:0]  cur_count,
  input logic              tmr_mask
);
  logic init_sel;
  assign init_sel = bus_we && (bus_addr == ADDR_W'(OFF_INIT));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector));

  // R8
  masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> !$past(tmr_mask));

  // R7
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_sel && bus_wdata[CNT_W-1:0] == '0 |=> cur_count == '0);

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count != '0 && !init_sel |=> cur_count <= $past(cur_count));
endmodule

bind lpt_timer lpt_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vector(irq_vector), .cur_count(cur_count), .tmr_mask(tmr_mask)
);

// File: tb/lpt_timer_tb.sv
`timescale 1ns/1ps
module lpt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b1;
  logic [7:0]  irq_vector;

  always #4 clk = ~clk;

  lpt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  typedef struct {
    logic [7:0] vec;
    int         cyc;   // -1: any cycle
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   hs_t[$];
  int   cyc = 0;
  int   nchk = 0, nfail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_irq(input logic [7:0] v, input int c, input string tag);
    exp_t e;
    e.vec = v; e.cyc = c; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: handshake seen at the negedge between the two edges
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      hs_t.push_back(cyc);
      if (exp_q.size() == 0) begin
        check(0, "R4 R7 R8 R11", "unexpected request vector", irq_vector, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(irq_vector == e.vec, e.tag, "request vector", irq_vector, e.vec);
        if (e.cyc >= 0) check(cyc == e.cyc, e.tag, "request cycle", cyc, e.cyc);
      end
    end
  end

  // tasks run with the caller 1ns after a posedge
  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int c);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    c = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v, output int k);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata; k = cyc;
    @(posedge clk); #1;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R1", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c0, c1, k, base;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(12'h320, v, k); check(v == 32'h0001_0000, "R1", "vector entry", v, 32'h0001_0000);
    rd(12'h380, v, k); check(v == 0, "R1", "initial count", v, 0);
    rd(12'h390, v, k); check(v == 0, "R1", "current count", v, 0);
    rd(12'h3E0, v, k); check(v == 0, "R1", "divide config", v, 0);
    check(irq_valid == 0, "R1", "irq_valid", irq_valid, 0);

    // R2 layout
    wr(12'h320, 32'hFFFF_FFFF, c0);
    rd(12'h320, v, k); check(v == 32'h0003_00FF, "R2", "vector entry fields", v, 32'h0003_00FF);
    wr(12'h3E0, 32'hFFFF_FFFF, c0);
    rd(12'h3E0, v, k); check(v == 32'h0000_000B, "R2", "divide fields", v, 32'h0000_000B);
    rd(12'h324, v, k); check(v == 0, "R2", "unmapped address", v, 0);

    // R3 / R4 one-shot, divide-by-1, vector 0x21
    wr(12'h320, 32'h0000_0021, c0);
    wr(12'h380, 32'd10, c0);
    expect_irq(8'h21, c0 + 10, "R4");
    rd(12'h390, v, k); check(v == 32'(10 - (k - c0)), "R3", "counting", v, 10 - (k - c0));
    idle(2);
    rd(12'h390, v, k); check(v == 32'(10 - (k - c0)), "R3", "counting later", v, 10 - (k - c0));
    wait_to(c0 + 14);
    rd(12'h390, v, k); check(v == 0, "R4", "stopped at zero", v, 0);
    idle(20);

    // R9 current count is read-only
    wr(12'h390, 32'h55, c1);
    rd(12'h390, v, k); check(v == 0, "R9", "write to current ignored", v, 0);

    // R5 periodic, then R7 stop with zero
    wr(12'h320, 32'h0002_0022, c1);
    wr(12'h380, 32'd5, c0);
    expect_irq(8'h22, c0 + 5,  "R5");
    expect_irq(8'h22, c0 + 11, "R5");
    expect_irq(8'h22, c0 + 17, "R5");
    wait_to(c0 + 18);
    wr(12'h380, 32'd0, c1);
    rd(12'h390, v, k); check(v == 0, "R7", "count after zero write", v, 0);
    idle(20);
    rd(12'h390, v, k); check(v == 0, "R7", "still stopped", v, 0);

    // R6 divide-by-2 (code 000), init 3 -> interval 8
    wr(12'h3E0, 32'h0, c1);
    wr(12'h320, 32'h0002_0023, c1);
    base = hs_t.size();
    expect_irq(8'h23, -1, "R6");
    expect_irq(8'h23, -1, "R6");
    wr(12'h380, 32'd3, c0);
    while (hs_t.size() < base + 2) @(posedge clk);
    #1 wr(12'h380, 32'd0, c1);
    check(hs_t[base+1] - hs_t[base] == 8, "R6", "interval div2", hs_t[base+1] - hs_t[base], 8);

    // R6 divide-by-64 (code 101 = 0x9), init 1 -> interval 128
    wr(12'h3E0, 32'h9, c1);
    base = hs_t.size();
    expect_irq(8'h23, -1, "R6");
    expect_irq(8'h23, -1, "R6");
    wr(12'h380, 32'd1, c0);
    while (hs_t.size() < base + 2) @(posedge clk);
    #1 wr(12'h380, 32'd0, c1);
    check(hs_t[base+1] - hs_t[base] == 128, "R6", "interval div64", hs_t[base+1] - hs_t[base], 128);
    idle(300);

    // R8 masked expiry discarded, unmask later raises nothing
    wr(12'h3E0, 32'hB, c1);
    wr(12'h320, 32'h0001_0024, c1);
    wr(12'h380, 32'd6, c0);
    wait_to(c0 + 10);
    check(irq_valid == 0, "R8", "masked expiry", irq_valid, 0);
    wr(12'h320, 32'h0000_0024, c1);
    idle(10);
    check(irq_valid == 0, "R8", "no stale request after unmask", irq_valid, 0);

    // R8 unmask mid-count keeps count
    wr(12'h320, 32'h0001_0024, c1);
    wr(12'h380, 32'd20, c0);
    idle(4);
    wr(12'h320, 32'h0000_0024, c1);
    rd(12'h390, v, k); check(v == 32'(20 - (k - c0)), "R8", "count after unmask", v, 20 - (k - c0));
    expect_irq(8'h24, c0 + 20, "R8");
    wait_to(c0 + 30);

    // R10 / R11 back-pressure with one pending
    irq_ready = 1'b0;
    wr(12'h320, 32'h0002_0025, c1);
    wr(12'h380, 32'd2, c0);
    wait_to(c0 + 2);
    wr(12'h320, 32'h0002_0026, c1);    // edge c0+3
    @(negedge clk);
    check(irq_valid == 1, "R10", "valid held", irq_valid, 1);
    check(irq_vector == 8'h25, "R10", "vector held", irq_vector, 8'h25);
    wait_to(c0 + 9);
    wr(12'h380, 32'd0, c1);            // edge c0+10 stops timer
    @(negedge clk);
    check(irq_valid == 1, "R10", "valid still held", irq_valid, 1);
    check(irq_vector == 8'h25, "R10", "vector still held", irq_vector, 8'h25);
    @(posedge clk); #1;
    expect_irq(8'h25, -1, "R10");
    expect_irq(8'h26, -1, "R11");
    irq_ready = 1'b1;
    idle(12);
    check(irq_valid == 0, "R11", "third expiry dropped", irq_valid, 0);

    check(exp_q.size() == 0, "R4", "missing requests", exp_q.size(), 0);
    finish_run();
  end
endmodule